// File: doc/BRIEF.md
# Four-Bit Selectable Logic and Arithmetic Slice

This block is a purely combinational four-bit ALU slice. It takes two four-bit operands, a four-bit function code and a mode bit. In logic mode, each result bit is one of the sixteen possible Boolean functions of the matching operand bits. In arithmetic mode, the slice forms one of sixteen sums of two operand-derived words, with an optional carry.

The carry input and carry output are active-low with respect to the data. This means slices chain directly: one slice's carry output drives the next slice's carry input, which gives wider adders and subtractors. For faster chaining, an external lookahead unit can use the group propagate and group generate outputs instead. Neither of these outputs depends on the carry input.

An all-ones flag on the result gives an equality test when the slice runs the subtract code without carry.

Internally, every bit derives two words from the operands and the function code:
- X[i] = A[i] | (B[i] & S[0]) | (~B[i] & S[1])
- Y[i] = (A[i] & B[i] & S[3]) | (A[i] & ~B[i] & S[2])

Arithmetic results, carries and group terms are all defined on these words. Here c is 1 when `carry_in_n` is low.

Top module: `alu4_slice`

## Requirements
- R1: With `logic_mode` high, each result bit depends only on its own operand bits (a,b). The value is ~S[1] for (0,0), ~S[0] for (0,1), S[2] for (1,0) and S[3] for (1,1). As examples, code 0110 gives XOR, code 1001 gives XNOR, code 0011 gives all zeros and code 1100 gives all ones.
- R2: With `logic_mode` high, the result does not change when `carry_in_n` changes.
- R3: With `logic_mode` low, the result is (X + Y + c) mod 16.
- R4: In arithmetic mode the named codes behave as follows:
  - 1001 gives A plus B.
  - 0110 gives A minus B minus 1 without carry, and A minus B with carry.
  - 1100 gives A plus A, a one-place shift toward the MSB.
  - 0000 gives A.
  - 1111 gives A minus 1.
- R5: `carry_out_n` is low exactly when X + Y + c is at least 16, in either mode. For code 0110 this means low for no borrow and high on underflow.
- R6: `grp_gen` is high exactly when X + Y is at least 16, and `grp_prop` is high exactly when X is 1111. Neither output depends on `carry_in_n`.
- R7: `all_ones` is high exactly when the result is 1111. With code 0110, arithmetic mode and no carry, it is high exactly when A equals B.
- R8: Four slices chained through their carry pins form a 16-bit unit. With code 1001 it computes A + B + c. With code 0110 it computes A - B - 1 + c. The final carry output follows the same active-low rule as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 4 | Operand A |
| op_b | input | 4 | Operand B |
| fsel | input | 4 | Function code S |
| logic_mode | input | 1 | High: bitwise logic; low: arithmetic |
| carry_in_n | input | 1 | Active-low carry into bit 0 |
| res | output | 4 | Result F |
| carry_out_n | output | 1 | Active-low carry out of bit 3 |
| grp_prop | output | 1 | Group propagate, independent of carry in |
| grp_gen | output | 1 | Group generate, independent of carry in |
| all_ones | output | 1 | High when every result bit is 1 |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle the stimulus is applied, with zero register stages. The bench changes inputs shortly after a rising edge and samples all outputs at the following falling edge. This gives the logic settling time and makes no check depend on process order at an edge. The single slice is checked over the full input space, with expected values computed from the X/Y word rules. The four-slice chain is checked on wraparound and borrow cases.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int SLICE_W = 4;
  localparam int SEL_W   = 4;
  // function-code bit roles in the per-bit word formation
  localparam int SEL_X_B  = 0;
  localparam int SEL_X_NB = 1;
  localparam int SEL_Y_NB = 2;
  localparam int SEL_Y_B  = 3;
  typedef logic [SEL_W-1:0] fsel_t;
endpackage

// File: rtl/alu4_bit_terms.sv
module alu4_bit_terms
  import alu4_pkg::*;
#(
  parameter int W = SLICE_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fsel_t        sel,
  output logic [W-1:0] prop,
  output logic [W-1:0] gen,
  output logic [W-1:0] half
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic xw, yw;
    assign xw = a[i] | (b[i] & sel[SEL_X_B]) | (~b[i] & sel[SEL_X_NB]);
    assign yw = (a[i] & b[i] & sel[SEL_Y_B]) | (a[i] & ~b[i] & sel[SEL_Y_NB]);
    assign prop[i] = xw;
    assign gen[i]  = yw;
    assign half[i] = xw ^ yw;
  end
endmodule

// File: rtl/alu4_lookahead.sv
module alu4_lookahead #(
  parameter int W = 4
) (
  input  logic [W-1:0] prop,
  input  logic [W-1:0] gen,
  input  logic         cin,
  output logic [W-1:0] cbit,
  output logic         cout,
  output logic         gp,
  output logic         gg
);
  logic [W:0] carry;

  // each carry as a flat sum of products of the bit terms
  always_comb begin
    logic acc, term;
    carry[0] = cin;
    for (int i = 1; i <= W; i++) begin
      acc = cin;
      for (int k = 0; k < i; k++) acc = acc & prop[k];
      for (int j = 0; j < i; j++) begin
        term = gen[j];
        for (int k = j + 1; k < i; k++) term = term & prop[k];
        acc = acc | term;
      end
      carry[i] = acc;
    end
  end

  always_comb begin
    logic acc, term;
    acc = 1'b0;
    for (int j = 0; j < W; j++) begin
      term = gen[j];
      for (int k = j + 1; k < W; k++) term = term & prop[k];
      acc = acc | term;
    end
    gg = acc;
    gp = &prop;
  end

  assign cbit = carry[W-1:0];
  assign cout = carry[W];
endmodule

// File: rtl/alu4_result.sv
module alu4_result #(
  parameter int W = 4
) (
  input  logic [W-1:0] half,
  input  logic [W-1:0] cbit,
  input  logic         lmode,
  output logic [W-1:0] f,
  output logic         eq
);
  for (genvar i = 0; i < W; i++) begin : g_out
    assign f[i] = lmode ? ~half[i] : (half[i] ^ cbit[i]);
  end
  assign eq = &f;
endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
  import alu4_pkg::*;
(
  input  logic [SLICE_W-1:0] op_a,
  input  logic [SLICE_W-1:0] op_b,
  input  logic [SEL_W-1:0]   fsel,
  input  logic               logic_mode,
  input  logic               carry_in_n,
  output logic [SLICE_W-1:0] res,
  output logic               carry_out_n,
  output logic               grp_prop,
  output logic               grp_gen,
  output logic               all_ones
);
  localparam int W = SLICE_W;

  logic [W-1:0] p_w, g_w, h_w, c_w;
  logic         c_top;

  alu4_bit_terms #(.W(W)) u_terms (
    .a(op_a), .b(op_b), .sel(fsel),
    .prop(p_w), .gen(g_w), .half(h_w)
  );

  alu4_lookahead #(.W(W)) u_la (
    .prop(p_w), .gen(g_w), .cin(~carry_in_n),
    .cbit(c_w), .cout(c_top), .gp(grp_prop), .gg(grp_gen)
  );

  alu4_result #(.W(W)) u_res (
    .half(h_w), .cbit(c_w), .lmode(logic_mode),
    .f(res), .eq(all_ones)
  );

  assign carry_out_n = ~c_top;
endmodule

// File: rtl/alu4_slice_chk.sv
module alu4_slice_chk
  import alu4_pkg::*;
(
  input logic [SLICE_W-1:0] op_a,
  input logic [SLICE_W-1:0] op_b,
  input logic [SEL_W-1:0]   fsel,
  input logic               logic_mode,
  input logic               carry_in_n,
  input logic [SLICE_W-1:0] res,
  input logic               carry_out_n,
  input logic               grp_prop,
  input logic               grp_gen,
  input logic               all_ones
);
  localparam int W = SLICE_W;
  logic [W-1:0] tbl;
  logic [W-1:0] xs, ys;
  logic [W+1:0] tot;
  logic         known;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      case ({op_a[i], op_b[i]})
        2'b00:   tbl[i] = ~fsel[1];
        2'b01:   tbl[i] = ~fsel[0];
        2'b10:   tbl[i] = fsel[2];
        default: tbl[i] = fsel[3];
      endcase
      xs[i] = op_a[i] | (op_b[i] ? fsel[0] : fsel[1]);
      ys[i] = op_a[i] & (op_b[i] ? fsel[3] : fsel[2]);
    end
    tot = {2'b00, xs} + {2'b00, ys} + {{(W+1){1'b0}}, ~carry_in_n};
    known = !$isunknown({op_a, op_b, fsel, logic_mode, carry_in_n,
                         res, carry_out_n, grp_prop, grp_gen, all_ones});
  end

  always_comb begin
    if (known) begin
      assert_logic_table_R1: assert (!logic_mode || res == tbl)
        else $error("logic result %h expected %h", res, tbl);
      assert_arith_sum_R3: assert (logic_mode || res == tot[W-1:0])
        else $error("arith result %h expected %h", res, tot[W-1:0]);
      assert_carry_rule_R5: assert (carry_out_n == !(grp_gen | (grp_prop & ~carry_in_n)))
        else $error("carry out disagrees with group terms");
      assert_group_gen_R6: assert (grp_gen == (({1'b0, xs} + {1'b0, ys}) >= 16))
        else $error("group generate wrong");
      assert_all_ones_R7: assert (all_ones == (res == {W{1'b1}}))
        else $error("all-ones flag wrong");
    end
  end
endmodule

bind alu4_slice alu4_slice_chk u_chk (
  .op_a(op_a), .op_b(op_b), .fsel(fsel), .logic_mode(logic_mode),
  .carry_in_n(carry_in_n), .res(res), .carry_out_n(carry_out_n),
  .grp_prop(grp_prop), .grp_gen(grp_gen), .all_ones(all_ones)
);

// File: tb/tb_alu4_slice.sv
module tb_alu4_slice;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [3:0] a, b, s;
  logic       m, cn;
  logic [3:0] f;
  logic       co, gp, gg, eq;

  alu4_slice dut (
    .op_a(a), .op_b(b), .fsel(s), .logic_mode(m), .carry_in_n(cn),
    .res(f), .carry_out_n(co), .grp_prop(gp), .grp_gen(gg), .all_ones(eq)
  );

  // 16-bit ripple chain
  logic [15:0] wa, wb, wf;
  logic [3:0]  ws;
  logic        wm, wcn;
  logic [4:0]  wc;
  assign wc[0] = wcn;
  for (genvar k = 0; k < 4; k++) begin : g_cas
    logic up_p, up_g, up_e;
    alu4_slice u_cas (
      .op_a(wa[4*k +: 4]), .op_b(wb[4*k +: 4]), .fsel(ws), .logic_mode(wm),
      .carry_in_n(wc[k]), .res(wf[4*k +: 4]), .carry_out_n(wc[k+1]),
      .grp_prop(up_p), .grp_gen(up_g), .all_ones(up_e)
    );
  end

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h (s=%b m=%b a=%h b=%h cn=%b)", tag, got, exp, s, m, a, b, cn);
    end
  endtask

  task automatic drive(input logic [3:0] ts, input logic tm, input logic [3:0] ta,
                       input logic [3:0] tb, input logic tcn);
    @(posedge clk);
    #1;
    s = ts; m = tm; a = ta; b = tb; cn = tcn;
    @(negedge clk);
  endtask

  // {s, m, a, b, cn, f, cout_n, eq}
  localparam int NV = 18;
  localparam logic [19:0] VEC [NV] = '{
    {4'b1001, 1'b0, 4'h3, 4'h5, 1'b1, 4'h8, 1'b1, 1'b0},
    {4'b1001, 1'b0, 4'h9, 4'h7, 1'b1, 4'h0, 1'b0, 1'b0},
    {4'b1001, 1'b0, 4'hF, 4'hF, 1'b0, 4'hF, 1'b0, 1'b1},
    {4'b0110, 1'b0, 4'h7, 4'h3, 1'b1, 4'h3, 1'b0, 1'b0},
    {4'b0110, 1'b0, 4'h7, 4'h3, 1'b0, 4'h4, 1'b0, 1'b0},
    {4'b0110, 1'b0, 4'h5, 4'h5, 1'b1, 4'hF, 1'b1, 1'b1},
    {4'b0110, 1'b0, 4'h3, 4'h7, 1'b0, 4'hC, 1'b1, 1'b0},
    {4'b1100, 1'b0, 4'h9, 4'h0, 1'b1, 4'h2, 1'b0, 1'b0},
    {4'b1100, 1'b0, 4'h6, 4'hF, 1'b1, 4'hC, 1'b1, 1'b0},
    {4'b0000, 1'b0, 4'hA, 4'h3, 1'b1, 4'hA, 1'b1, 1'b0},
    {4'b0000, 1'b0, 4'hA, 4'h3, 1'b0, 4'hB, 1'b1, 1'b0},
    {4'b1111, 1'b0, 4'h0, 4'h0, 1'b1, 4'hF, 1'b1, 1'b1},
    {4'b1111, 1'b0, 4'h5, 4'h9, 1'b1, 4'h4, 1'b0, 1'b0},
    {4'b1111, 1'b0, 4'h5, 4'h9, 1'b0, 4'h5, 1'b0, 1'b0},
    {4'b0110, 1'b1, 4'hC, 4'hA, 1'b1, 4'h6, 1'b0, 1'b0},
    {4'b1001, 1'b1, 4'hC, 4'hA, 1'b1, 4'h9, 1'b0, 1'b0},
    {4'b0011, 1'b1, 4'h5, 4'h3, 1'b0, 4'h0, 1'b0, 1'b0},
    {4'b1100, 1'b1, 4'h5, 4'h3, 1'b1, 4'hF, 1'b1, 1'b1}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    s = 4'h0; m = 1'b0; a = 4'h0; b = 4'h0; cn = 1'b1;
    ws = 4'h0; wm = 1'b0; wa = 16'h0; wb = 16'h0; wcn = 1'b1;
    @(negedge clk);
    // idle pattern after start-up
    check("R3 idle result", {12'h0, f}, 16'h0000);
    check("R5 idle carry", {15'h0, co}, 16'h0001);
    check("R6 idle group", {14'h0, gp, gg}, 16'h0000);
    check("R7 idle flag", {15'h0, eq}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      drive(v[19:16], v[15], v[14:11], v[10:7], v[6]);
      check(v[15] ? "R1 table result" : "R4 table result", {12'h0, f}, {12'h0, v[5:2]});
      check("R5 table carry", {15'h0, co}, {15'h0, v[1]});
      check("R7 table flag", {15'h0, eq}, {15'h0, v[0]});
    end

    // exhaustive single slice
    for (int si = 0; si < 16; si++) begin
      for (int mi = 0; mi < 2; mi++) begin
        for (int ai = 0; ai < 16; ai++) begin
          for (int bi = 0; bi < 16; bi++) begin
            logic [3:0] fz, xr, yr, tl;
            logic       pz, gz;
            for (int ci = 1; ci >= 0; ci--) begin
              logic [5:0] sum;
              logic [3:0] ef;
              for (int k = 0; k < 4; k++) begin
                xr[k] = ai[k] | (bi[k] ? si[0] : si[1]);
                yr[k] = ai[k] & (bi[k] ? si[3] : si[2]);
                case ({ai[k], bi[k]})
                  2'b00:   tl[k] = ~si[1];
                  2'b01:   tl[k] = ~si[0];
                  2'b10:   tl[k] = si[2];
                  default: tl[k] = si[3];
                endcase
              end
              sum = {2'b0, xr} + {2'b0, yr} + {5'b0, (ci == 0)};
              ef = (mi == 1) ? tl : sum[3:0];
              drive(si[3:0], mi[0], ai[3:0], bi[3:0], ci[0]);
              check(mi == 1 ? "R1 logic result" : "R3 arith result", {12'h0, f}, {12'h0, ef});
              check("R5 carry out", {15'h0, co}, {15'h0, ~(sum >= 16)});
              check("R6 group gen", {15'h0, gg}, {15'h0, (({2'b0, xr} + {2'b0, yr}) >= 16)});
              check("R6 group prop", {15'h0, gp}, {15'h0, (xr == 4'hF)});
              check("R7 all ones", {15'h0, eq}, {15'h0, (ef == 4'hF)});
              if (ci == 1) begin
                fz = f; pz = gp; gz = gg;
              end else begin
                if (mi == 1) check("R2 carry ignored", {12'h0, f}, {12'h0, fz});
                check("R6 carry-free group", {14'h0, gp, gg}, {14'h0, pz, gz});
              end
            end
          end
        end
      end
    end

    // 16-bit ripple chain
    for (int t = 0; t < 6; t++) begin
      logic [16:0] e;
      logic [15:0] ta, tb2;
      logic        tc, sub;
      case (t)
        0: begin ta = 16'h1234; tb2 = 16'h0FFF; tc = 1'b0; sub = 1'b0; end
        1: begin ta = 16'hFFFF; tb2 = 16'h0001; tc = 1'b0; sub = 1'b0; end
        2: begin ta = 16'h8000; tb2 = 16'h0001; tc = 1'b1; sub = 1'b1; end
        3: begin ta = 16'h0001; tb2 = 16'h0002; tc = 1'b1; sub = 1'b1; end
        4: begin ta = 16'hABCD; tb2 = 16'hABCD; tc = 1'b0; sub = 1'b1; end
        default: begin ta = 16'h7FFF; tb2 = 16'h8000; tc = 1'b1; sub = 1'b0; end
      endcase
      e = {1'b0, ta} + {1'b0, (sub ? ~tb2 : tb2)} + {16'h0, tc};
      @(posedge clk);
      #1;
      wa = ta; wb = tb2; ws = sub ? 4'b0110 : 4'b1001; wm = 1'b0; wcn = ~tc;
      @(negedge clk);
      check("R8 chain result", wf, e[15:0]);
      check("R8 chain carry", {15'h0, wc[4]}, {15'h0, ~e[16]});
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule